// File: doc/BRIEF.md
# Chained Converter Readback Controller

This block runs, from the host side, a chain of serial analog-to-digital converters linked in a daisy chain over three wires. The wires are a conversion strobe, a serial clock and one return data line from the converter nearest the host. On a start request it drives the serial clock high and then raises the conversion strobe. With the clock high at that moment, the converters enter chained operation with a busy indication. The controller then holds the strobe high and waits for the return line to go from low to high. That change shows that every converter in the chain has finished.

After the ready change it issues exactly 16·N+1 serial clock pulses and samples the return line at each falling clock edge. The first sampled bit is the ready level and is dropped. The remaining 16·N bits are gathered into N words, one per converter, and the words are presented on a parallel output together with a one-cycle valid strobe. If the ready change does not arrive within a set number of system clocks, the controller reports an error and returns to idle.

Top module: `chain_adc_reader`

## Requirements
- R1: After reset, cnv_o, sck_o, busy_o, valid_o and err_o are all low.
- R2: On start_i in idle, sck_o rises first and stays high for exactly HALF_DIV system clocks with cnv_o low. cnv_o then rises while sck_o is still high.
- R3: While waiting for ready, sck_o stays high and has no falling edge. Ready is a low-to-high change of sdi_i. A line that is already high when the wait begins is not ready until it has gone low and then high again.
- R4: After ready, sck_o shows exactly 16·N_DEV+1 falling edges. During readback each high and each low level lasts HALF_DIV system clocks.
- R5: sdi_i is sampled at each clock edge that drives sck_o low. The first sample is discarded. The next 16·N_DEV samples form the words MSB first. Word k (k=0 is the converter nearest the host, which arrives first) appears on data_o[16k+15:16k].
- R6: cnv_o stays high from its rise until the last falling edge of sck_o. In the cycle of that edge, cnv_o and sck_o go low and valid_o is high for exactly one cycle.
- R7: busy_o is high from the cycle cnv_o rises up to the cycle before valid_o (or err_o). It is low while valid_o is high.
- R8: If no ready change arrives, then RDY_TMO clocks after cnv_o rises err_o pulses for one cycle, cnv_o and sck_o go low, and valid_o stays low.
- R9: A start_i request made while a transaction is in progress (lead-in, wait or readback) is ignored. Each transaction raises cnv_o exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one chained conversion and readback |
| sdi_i | input | 1 | Return data line from the nearest converter |
| cnv_o | output | 1 | Conversion strobe to all converters |
| sck_o | output | 1 | Serial clock to all converters |
| busy_o | output | 1 | Transaction in progress |
| data_o | output | 16·N_DEV | Captured words, word 0 in the low bits |
| valid_o | output | 1 | One-cycle strobe marking data_o as new |
| err_o | output | 1 | One-cycle pulse on ready timeout |

## Verification
The bench tries the chain with three patterns:
- Alternating bits and single set bits at the word ends. This separates MSB-first from LSB-first capture and shows any word swap.
- All-ones and all-zeros words in turn. This exposes an off-by-one sample, which would leak the ready bit or lose the last bit.
- A return line held high before the start. This tells a true low-to-high ready change apart from a level check.

Short and long conversion delays, a run with no ready change at all, and extra start requests during a transaction show timeout handling and that extra starts are ignored. A further transaction after the timeout shows the controller recovers.

// File: rtl/chain_adc_reader.sv
module chain_adc_reader #(
  parameter int N_DEV    = 3,
  parameter int WORD_W   = 16,
  parameter int HALF_DIV = 2,
  parameter int RDY_TMO  = 1000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    sdi_i,
  output logic                    cnv_o,
  output logic                    sck_o,
  output logic                    busy_o,
  output logic [N_DEV*WORD_W-1:0] data_o,
  output logic                    valid_o,
  output logic                    err_o
);
  localparam int NBITS = N_DEV * WORD_W;
  localparam int NEDGE = NBITS + 1;
  localparam int HW    = $clog2(HALF_DIV + 1);
  localparam int EW    = $clog2(NEDGE + 1);
  localparam int TW    = $clog2(RDY_TMO + 1);

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_WAIT, S_SHIFT} st_t;

  st_t              st;
  logic             cnv_q, sck_q, valid_q, err_q, sdi_prev;
  logic [HW-1:0]    hcnt;
  logic [EW-1:0]    ecnt;
  logic [TW-1:0]    tcnt;
  logic [NBITS-1:0] shreg;

  wire half_done = (hcnt == HW'(HALF_DIV - 1));
  wire rdy_edge  = sdi_i & ~sdi_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnv_q    <= 1'b0;
      sck_q    <= 1'b0;
      valid_q  <= 1'b0;
      err_q    <= 1'b0;
      sdi_prev <= 1'b1;
      hcnt     <= '0;
      ecnt     <= '0;
      tcnt     <= '0;
      shreg    <= '0;
    end else begin
      sdi_prev <= sdi_i;
      valid_q  <= 1'b0;
      err_q    <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          sck_q <= 1'b1;
          hcnt  <= '0;
          st    <= S_LEAD;
        end
        S_LEAD: if (half_done) begin
          cnv_q <= 1'b1;
          tcnt  <= '0;
          st    <= S_WAIT;
        end else hcnt <= hcnt + 1'b1;
        S_WAIT: if (rdy_edge) begin
          hcnt <= '0;
          ecnt <= '0;
          st   <= S_SHIFT;
        end else if (tcnt == TW'(RDY_TMO - 1)) begin
          err_q <= 1'b1;
          cnv_q <= 1'b0;
          sck_q <= 1'b0;
          st    <= S_IDLE;
        end else tcnt <= tcnt + 1'b1;
        S_SHIFT: if (!half_done) hcnt <= hcnt + 1'b1;
        else begin
          hcnt <= '0;
          if (sck_q) begin
            sck_q <= 1'b0;
            shreg <= {shreg[NBITS-2:0], sdi_i};
            if (ecnt == EW'(NEDGE - 1)) begin
              cnv_q   <= 1'b0;
              valid_q <= 1'b1;
              st      <= S_IDLE;
            end else ecnt <= ecnt + 1'b1;
          end else sck_q <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cnv_o   = cnv_q;
  assign sck_o   = sck_q;
  assign busy_o  = cnv_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;

  for (genvar k = 0; k < N_DEV; k++) begin : g_word
    assign data_o[k*WORD_W +: WORD_W] = shreg[(N_DEV-1-k)*WORD_W +: WORD_W];
  end

  p_cnv_rise_sck_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_q) |-> sck_q && $past(sck_q));
  p_no_fall_in_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |-> sck_q);
  p_edge_total_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(ecnt) == EW'(NEDGE - 1));
  p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  p_valid_lines_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> !cnv_q && !sck_q && $past(cnv_q));
  p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !cnv_q && !sck_q && !valid_q && $past(st == S_WAIT));
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && start_i) |=> st != S_LEAD || $past(st == S_LEAD));
endmodule

// File: tb/chain_adc_reader_tb.sv
module chain_adc_reader_tb;
  localparam int N = 3, W = 16, HALF = 2, TMO = 200;
  localparam int NE = N * W + 1;

  logic clk = 0, rst_n = 0, start_i = 0, sdi_i = 0;
  logic cnv_o, sck_o, busy_o, valid_o, err_o;
  logic [N*W-1:0] data_o;

  chain_adc_reader #(.N_DEV(N), .WORD_W(W), .HALF_DIV(HALF), .RDY_TMO(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sdi_i(sdi_i), .cnv_o(cnv_o),
    .sck_o(sck_o), .busy_o(busy_o), .data_o(data_o), .valid_o(valid_o), .err_o(err_o));

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  logic [W-1:0] exp_w[N];
  bit stream[$];
  int idx = 0;
  bit streaming = 0, rdy_given = 0, expect_err = 0;

  always @(negedge sck_o) if (streaming) begin
    #1;
    idx++;
    sdi_i = (idx < stream.size()) ? stream[idx] : 1'b0;
  end

  logic p_cnv = 0, p_sck = 0, p_valid = 0;
  int falls = 0, run = 0, hi_lead = 0, cnv_cyc = 0, rises = 0, n_valid = 0, n_err = 0;

  always @(negedge clk) if (rst_n) begin
    chk(busy_o == cnv_o, "R7", "busy tracks strobe", busy_o, cnv_o);
    if (sck_o && !cnv_o) hi_lead++;
    if (cnv_o) cnv_cyc++;
    if (cnv_o && !p_cnv) begin
      rises++;
      chk(p_sck && sck_o, "R2", "sck high at cnv rise", sck_o, 1);
      chk(hi_lead == HALF, "R2", "lead-in length", hi_lead, HALF);
      falls = 0;
    end
    if (sck_o != p_sck) begin
      if (p_cnv && falls >= 1) chk(run == HALF, "R4", "sck level length", run, HALF);
      if (!sck_o && p_cnv) begin
        chk(rdy_given, "R3", "sck fall before ready", 1, 0);
        falls++;
      end
      run = 1;
    end else run++;
    if (!cnv_o && !sck_o) hi_lead = 0;
    if (valid_o) begin
      n_valid++;
      chk(!p_valid, "R6", "valid length", 2, 1);
      chk(!cnv_o && !sck_o && p_cnv, "R6", "lines at valid", {cnv_o, sck_o}, 0);
      chk(falls == NE, "R4", "falling edge count", falls, NE);
      for (int k = 0; k < N; k++)
        chk(data_o[k*W +: W] == exp_w[k], "R5", $sformatf("word %0d", k), data_o[k*W +: W], exp_w[k]);
    end
    if (err_o) begin
      n_err++;
      chk(expect_err, "R8", "unexpected error", 1, 0);
      chk(cnv_cyc == TMO, "R8", "timeout delay", cnv_cyc, TMO);
      chk(!cnv_o && !sck_o && !valid_o, "R8", "lines at timeout", {cnv_o, sck_o, valid_o}, 0);
    end
    if (!cnv_o) cnv_cyc = 0;
    p_cnv = cnv_o; p_sck = sck_o; p_valid = valid_o;
  end

  task automatic pulse_start();
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
  endtask

  task automatic run_txn(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c, int dly, bit stuck, bit poke);
    int r0, v0;
    r0 = rises; v0 = n_valid;
    exp_w[0] = a; exp_w[1] = b; exp_w[2] = c;
    stream.delete();
    stream.push_back(1'b1);
    for (int k = 0; k < N; k++)
      for (int i = W - 1; i >= 0; i--) stream.push_back(exp_w[k][i]);
    rdy_given = 0; streaming = 0;
    if (stuck) sdi_i = 1;
    pulse_start();
    wait (cnv_o);
    if (poke) pulse_start();
    repeat (dly) @(negedge clk);
    if (stuck) begin
      chk(sck_o && cnv_o && falls == 0, "R3", "held-high line taken as ready", falls, 0);
      sdi_i = 0;
      repeat (3) @(negedge clk);
    end
    rdy_given = 1; idx = 0; streaming = 1; sdi_i = 1;
    if (poke) begin repeat (9) @(negedge clk); pulse_start(); end
    wait (n_valid != v0);
    repeat (30) @(negedge clk);
    streaming = 0;
    chk(rises - r0 == 1, "R9", "strobe rises per transaction", rises - r0, 1);
    chk(n_valid - v0 == 1 && !cnv_o, "R9", "valid per transaction", n_valid - v0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({cnv_o, sck_o, busy_o, valid_o, err_o} == 0, "R1", "outputs in reset",
        {cnv_o, sck_o, busy_o, valid_o, err_o}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk({cnv_o, sck_o, busy_o, valid_o, err_o} == 0, "R1", "outputs after reset",
        {cnv_o, sck_o, busy_o, valid_o, err_o}, 0);
    run_txn(16'hA5C3, 16'h0001, 16'h8000, 20, 0, 0);
    run_txn(16'hFFFF, 16'h0000, 16'hFFFF, 3, 0, 1);
    run_txn(16'h1234, 16'h5678, 16'h9ABC, 10, 1, 0);
    begin
      int v0;
      v0 = n_valid;
      expect_err = 1; sdi_i = 0;
      pulse_start();
      repeat (TMO + 20) @(negedge clk);
      expect_err = 0;
      chk(n_err == 1, "R8", "error pulses", n_err, 1);
      chk(n_valid == v0 && !cnv_o && !sck_o, "R8", "no valid after timeout", n_valid - v0, 0);
    end
    run_txn(16'h0F0F, 16'hF0F0, 16'h7FFE, 57, 0, 0);
    run_txn(16'h8001, 16'h4002, 16'h2004, 1, 0, 1);
    finish_run();
  end
endmodule